// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a count split into a low byte and a high byte. When enabled, it advances by one either on an internal machine-cycle tick or on a falling edge of its own external count pin. A shared mode register gives each channel a counting mode, a source select and a gate select. A shared control register holds the two run bits and the two overflow flags. The flags are also brought out as pins for an interrupt controller, which clears them through per-timer acknowledge inputs.

Software reaches the six registers through a simple one-cycle register bus. A write takes effect at the clock edge on which `reg_we` is high. Reads are combinational from `reg_addr`. This block carries no data stream, so it has no valid/ready handshake: every pin is a plain level or a one-cycle strobe, with no back-pressure.

Top module: `tmr_pair`

## Requirements
- R1: After reset every count byte, the mode register and the control register read as zero, and both flag outputs are low.
- R2: Register addresses are 0 control, 1 mode, 2/3 channel 0 low/high byte, and 4/5 channel 1 low/high byte. In the control register, bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1. In the mode register, channel 0 uses bits 3:0 and channel 1 uses bits 7:4. Within each nibble, bits 1:0 are the mode, bit 2 is the source select and bit 3 is the gate select.
- R3: A channel advances only while its run bit is set and either its gate select is 0 or its gate pin is high. If any condition fails, the count holds.
- R4: In mode 1 the whole 16-bit count increments. On the wrap from FFFFh to 0000h it sets the channel's flag and does not reload.
- R5: In mode 0 the low byte and bits 4:0 of the high byte form a 13-bit count. High-byte bits 7:5 are never changed by counting. The wrap of the 13-bit count sets the flag.
- R6: In mode 2 only the low byte counts. When the low byte passes FFh it is loaded from the high byte and the flag is set. The high byte is unchanged.
- R7: In mode 3 on channel 0, the low byte is an 8-bit counter with channel 0's enable and its wrap sets flag 0. The high byte is an 8-bit counter that advances on each tick while run 1 is set, and its wrap sets flag 1.
- R8: While channel 0 is in mode 3, a wrap of channel 1 does not set flag 1. A channel 1 set to mode 3 holds its count.
- R9: With source select 1, a channel counts each falling edge of its count pin once, within three clock edges of that edge. It ignores rising edges and the tick.
- R10: A high acknowledge input clears its flag, but a hardware set in the same cycle wins over the acknowledge.
- R11: A software write to the control register decides the flags over a hardware set or acknowledge in the same cycle. A write to a count byte wins over counting of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Machine-cycle tick enable |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate pins, one per channel |
| irq_ack | input | 2 | Flag acknowledge, one per channel |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data |
| ovf_flag | output | 2 | Overflow flags |

## Verification
Channel 0 is run through each of the four modes from preset counts just below a wrap. The results show whether the carry is cut at 13 or 16 bits, whether the top three high-byte bits are preserved, and whether the low byte reloads from the high byte. Runs with the gate pin low then high, and with the tick held while only pin edges arrive, separate the gated path from the ungated one and the tick source from the edge source. Split-mode runs with both counts at FFFFh and then with only channel 1 wrapping show which counter owns flag 1. Writes and acknowledges placed in the same cycle as a wrap confirm the priority order.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_MODE  = 1;
  localparam int ADDR_C0_LO = 2;
  localparam int ADDR_C0_HI = 3;
  localparam int ADDR_C1_LO = 4;
  localparam int ADDR_C1_HI = 5;

  localparam int CTRL_RUN_LSB  = 0;
  localparam int CTRL_FLAG_LSB = 2;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      prev_q <= sh_q[LAST];
    end
  end

  assign fall = prev_q & ~sh_q[LAST];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              inc,
  input  logic              hi_inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap_main,
  output logic              wrap_hi
);
  localparam int W13 = PRE_W + BYTE_W;
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [W13:0]      s13;
  logic [W16:0]      s16;
  logic [BYTE_W:0]   s8;
  logic              split_ok;

  generate
    if (HAS_SPLIT) begin : g_split
      assign split_ok = 1'b1;
    end else begin : g_nosplit
      assign split_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    lo_n      = lo;
    hi_n      = hi;
    wrap_main = 1'b0;
    wrap_hi   = 1'b0;
    s13       = {1'b0, hi[PRE_W-1:0], lo} + 1'b1;
    s16       = {1'b0, hi, lo} + 1'b1;
    s8        = {1'b0, lo} + 1'b1;
    unique case (mode)
      MODE_13: if (inc) begin
        lo_n              = s13[BYTE_W-1:0];
        hi_n[PRE_W-1:0]   = s13[BYTE_W +: PRE_W];
        wrap_main         = s13[W13];
      end
      MODE_16: if (inc) begin
        lo_n      = s16[BYTE_W-1:0];
        hi_n      = s16[BYTE_W +: BYTE_W];
        wrap_main = s16[W16];
      end
      MODE_RELOAD: if (inc) begin
        wrap_main = s8[BYTE_W];
        lo_n      = s8[BYTE_W] ? hi : s8[BYTE_W-1:0];
      end
      MODE_SPLIT: if (split_ok) begin
        if (inc) begin
          lo_n      = s8[BYTE_W-1:0];
          wrap_main = s8[BYTE_W];
        end
        if (hi_inc) begin
          hi_n    = hi + 1'b1;
          wrap_hi = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        irq_ack,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [1:0]        ovf_flag
);
  localparam int NCH   = 2;
  localparam int CFG_W = $bits(chan_cfg_t);

  logic [NCH-1:0]             run_q, flag_q;
  chan_cfg_t [NCH-1:0]        cfg_q;
  logic [NCH-1:0][BYTE_W-1:0] cnt_lo, cnt_hi;
  logic [NCH-1:0]             fall, inc, hi_inc, wrap_main, wrap_hi;
  logic [NCH-1:0]             wr_lo, wr_hi, set_hw;
  logic                       wr_ctrl, wr_mode, split0;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign wr_mode = reg_we && (reg_addr == ADDR_W'(ADDR_MODE));
  assign split0  = (cfg_q[0].mode == MODE_SPLIT);

  assign hi_inc[0] = run_q[1] & tick_en;
  assign hi_inc[1] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign wr_lo[g] = reg_we && (reg_addr == ADDR_W'(ADDR_C0_LO + 2 * g));
      assign wr_hi[g] = reg_we && (reg_addr == ADDR_W'(ADDR_C0_HI + 2 * g));
      assign inc[g]   = run_q[g] & (~cfg_q[g].gate | gate_pin[g]) &
                        (cfg_q[g].ext_src ? fall[g] : tick_en);

      tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cnt_pin[g]),
        .fall (fall[g])
      );

      tmr_channel #(
        .BYTE_W   (BYTE_W),
        .PRE_W    (PRE_W),
        .HAS_SPLIT(g == 0)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_q[g].mode),
        .inc      (inc[g]),
        .hi_inc   (hi_inc[g]),
        .wr_lo    (wr_lo[g]),
        .wr_hi    (wr_hi[g]),
        .wdata    (reg_wdata),
        .lo       (cnt_lo[g]),
        .hi       (cnt_hi[g]),
        .wrap_main(wrap_main[g]),
        .wrap_hi  (wrap_hi[g])
      );
    end
  endgenerate

  assign set_hw[0] = wrap_main[0];
  assign set_hw[1] = split0 ? wrap_hi[0] : (wrap_main[1] | wrap_hi[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_mode) cfg_q <= reg_wdata[NCH*CFG_W-1:0];
      if (wr_ctrl) begin
        run_q  <= reg_wdata[CTRL_RUN_LSB  +: NCH];
        flag_q <= reg_wdata[CTRL_FLAG_LSB +: NCH];
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (set_hw[c])       flag_q[c] <= 1'b1;
          else if (irq_ack[c]) flag_q[c] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_CTRL): begin
        reg_rdata[CTRL_RUN_LSB  +: NCH] = run_q;
        reg_rdata[CTRL_FLAG_LSB +: NCH] = flag_q;
      end
      ADDR_W'(ADDR_MODE):  reg_rdata[NCH*CFG_W-1:0] = cfg_q;
      ADDR_W'(ADDR_C0_LO): reg_rdata = cnt_lo[0];
      ADDR_W'(ADDR_C0_HI): reg_rdata = cnt_hi[0];
      ADDR_W'(ADDR_C1_LO): reg_rdata = cnt_lo[1];
      ADDR_W'(ADDR_C1_HI): reg_rdata = cnt_hi[1];
      default:             reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [BYTE_W-1:0]     reg_wdata,
  input logic [1:0]            irq_ack,
  input logic [1:0]            ovf_flag,
  input logic [1:0]            set_hw,
  input logic [1:0]            inc,
  input logic [1:0]            wr_lo,
  input logic [1:0]            wr_hi,
  input logic                  wr_ctrl,
  input logic [1:0][BYTE_W-1:0] cnt_lo,
  input logic [1:0][BYTE_W-1:0] cnt_hi,
  input logic [1:0]            ch1_mode
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc[0] && !wr_lo[0]) |=> $stable(cnt_lo[0]));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(2)) |=> (cnt_lo[0] == $past(reg_wdata)));

  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag[0]) |-> $past(set_hw[0] || wr_ctrl));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !set_hw[0] && !wr_ctrl) |=> !ovf_flag[0]);

  p_ch1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_mode == 2'd3 && !wr_lo[1] && !wr_hi[1]) |=>
      ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));
endmodule

bind tmr_pair tmr_pair_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq_ack  (irq_ack),
  .ovf_flag (ovf_flag),
  .set_hw   (set_hw),
  .inc      (inc),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .wr_ctrl  (wr_ctrl),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .ch1_mode (cfg_q[1].mode)
);

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int    src;
    logic [7:0] exp;
    string req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .ovf_flag(ovf_flag)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = (it.src == 0) ? reg_rdata : {7'd0, ovf_flag[it.src-1]};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.src = 0; it.exp = e; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic chk_flag(input int ch, input logic e, input string req);
    item_t it;
    @(posedge clk); #1;
    it.src = ch + 1; it.exp = {7'd0, e}; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic pin0_fall();
    @(posedge clk); #1 cnt_pin[0] = 1'b0;
    repeat (4) @(posedge clk);
    #1 cnt_pin[0] = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) chk_reg(3'(a), 8'h00, "R1 reset reg");
    chk_flag(0, 1'b0, "R1 flag0");
    chk_flag(1, 1'b0, "R1 flag1");

    // R4 16-bit mode
    wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01); wr(0, 8'h01);
    ticks(1);
    chk_reg(2, 8'hFF, "R4 lo before wrap");
    chk_flag(0, 1'b0, "R4 no flag yet");
    ticks(1);
    chk_reg(2, 8'h00, "R4 lo wrap");
    chk_reg(3, 8'h00, "R4 hi wrap");
    chk_flag(0, 1'b1, "R4 flag set");
    chk_reg(0, 8'h05, "R2 ctrl layout");

    // R10 acknowledge clears
    @(posedge clk); #1 irq_ack[0] = 1'b1;
    @(posedge clk); #1 irq_ack[0] = 1'b0;
    chk_flag(0, 1'b0, "R10 ack clears");

    // R5 13-bit mode
    wr(1, 8'h00); wr(2, 8'hFF); wr(3, 8'h03);
    ticks(1);
    chk_reg(3, 8'h04, "R5 carry into hi");
    chk_flag(0, 1'b0, "R5 no flag mid count");
    wr(2, 8'hFF); wr(3, 8'hFF);
    ticks(1);
    chk_reg(2, 8'h00, "R5 lo wrap");
    chk_reg(3, 8'hE0, "R5 hi top bits kept");
    chk_flag(0, 1'b1, "R5 flag set");
    wr(0, 8'h01);
    chk_flag(0, 1'b0, "R11 software clear");

    // R6 auto-reload
    wr(1, 8'h02); wr(3, 8'h80); wr(2, 8'hFE);
    ticks(2);
    chk_reg(2, 8'h80, "R6 reload");
    chk_reg(3, 8'h80, "R6 hi unchanged");
    chk_flag(0, 1'b1, "R6 flag set");
    ticks(1);
    chk_reg(2, 8'h81, "R6 counts on");
    wr(0, 8'h01);

    // R3 gating and run
    wr(1, 8'h09); wr(2, 8'h00); wr(3, 8'h00);
    ticks(3);
    chk_reg(2, 8'h00, "R3 gate pin low holds");
    gate_pin[0] = 1'b1;
    ticks(3);
    chk_reg(2, 8'h03, "R3 gate pin high counts");
    wr(0, 8'h00);
    ticks(2);
    chk_reg(2, 8'h03, "R3 run clear holds");
    gate_pin[0] = 1'b0;

    // R9 counter source
    wr(1, 8'h05); wr(0, 8'h01); wr(2, 8'h00);
    ticks(4);
    chk_reg(2, 8'h00, "R9 tick ignored");
    pin0_fall(); pin0_fall(); pin0_fall();
    chk_reg(2, 8'h03, "R9 falling edges counted");

    // R7 split mode
    wr(0, 8'h00); wr(1, 8'h13);
    wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    wr(0, 8'h03);
    ticks(1);
    chk_reg(2, 8'h00, "R7 split lo wrap");
    chk_reg(3, 8'h00, "R7 split hi wrap");
    chk_reg(5, 8'h00, "R7 ch1 still counts");
    chk_flag(0, 1'b1, "R7 flag0 from lo");
    chk_flag(1, 1'b1, "R7 flag1 from hi");
    wr(0, 8'h03);
    wr(2, 8'h10); wr(3, 8'h10); wr(4, 8'hFF); wr(5, 8'hFF);
    ticks(1);
    chk_reg(4, 8'h00, "R8 ch1 wrapped");
    chk_flag(1, 1'b0, "R8 ch1 wrap owns no flag");
    wr(0, 8'h01);
    ticks(2);
    chk_reg(2, 8'h13, "R7 split lo runs on run0");
    chk_reg(3, 8'h11, "R7 split hi needs run1");

    // R8 channel 1 in mode 3 holds
    wr(1, 8'h31); wr(4, 8'h20); wr(0, 8'h02);
    ticks(3);
    chk_reg(4, 8'h20, "R8 ch1 mode3 holds");

    // R11 priorities
    wr(1, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 8'h01);
    @(posedge clk); #1;
    tick_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01; reg_we = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0; reg_we = 1'b0;
    chk_flag(0, 1'b0, "R11 ctrl write beats set");
    chk_reg(2, 8'h00, "R11 count still wrapped");
    @(posedge clk); #1;
    tick_en = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h55; reg_we = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0; reg_we = 1'b0;
    chk_reg(2, 8'h55, "R11 byte write beats count");

    // R10 set beats acknowledge
    wr(2, 8'hFF); wr(3, 8'hFF);
    @(posedge clk); #1;
    tick_en = 1'b1; irq_ack[0] = 1'b1;
    @(posedge clk); #1;
    tick_en = 1'b0; irq_ack[0] = 1'b0;
    chk_flag(0, 1'b1, "R10 set beats ack");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule